// File: doc/BRIEF.md
# Binary Strip Readout Hit Buffer

This block is the digital back end of a 64-channel binary strip readout chip. On every trigger it captures the discriminator bits, with data-masked channels cleared, into an eight-deep event buffer. Triggers keep arriving while older events are read out. It also produces a combinational fast OR of the channels that the trigger mask leaves enabled. It drives per-channel calibration pulse enables, gated by a strobe. Three 64-bit masks load through a simple parallel write port.

Readout runs along a daisy chain of such chips. A read request (token) arrives from the downstream side. The chip then sends its own record for the oldest event. An empty record is a single 0 bit. A record with hits is a 1 bit followed by 64 hit bits. The chip then requests data from its upstream neighbour and forwards that stream until the upstream end marker. A direction input picks which side is downstream, so two controllers can split a line of chips between them. The chip that ends the chain marks its own final bit as last.

Top module: `strip_hit_buffer`

## Requirements
- R1: After reset the event buffer is empty, all three masks are zero, the overflow flag is 0, and all serial valid and token outputs are 0.
- R2: `fast_or_o` is the OR of `disc_i[i]` over all channels whose trigger-mask bit is 0. A trigger-mask bit of 1 removes the channel.
- R3: `cal_pulse_o[i]` equals calibration-mask bit i AND `cal_strobe_i`.
- R4: A write with `cfg_we_i`=1 loads `cfg_data_i` into the calibration mask (sel 0), the trigger mask (sel 1) or the data mask (sel 2). It takes effect from the next cycle. Sel 3 changes no mask.
- R5: A trigger captures `disc_i` AND NOT data-mask at that clock edge as a new event. Up to 8 events are held and read oldest first. Triggers are accepted during a readout.
- R6: A trigger that arrives while 8 events are held is discarded and sets `ovf_o`. `ovf_o` stays 1 until reset.
- R7: A record whose captured hits are all zero is one 0 bit. Otherwise it is a 1 bit followed by the 64 captured bits, channel 0 first.
- R8: A token received while idle with at least one event held puts the header bit on the serial output in the next cycle. The record bits follow on consecutive cycles.
- R9: With `chain_end_i`=1 the final own bit carries last=1 and the event is released. Otherwise own bits carry last=0. One cycle after the record, a one-cycle upstream token is issued. Upstream bits are then forwarded with one cycle of delay, up to and including the upstream bit marked last, and then the event is released.
- R10: With `dir_i`=0 the left side is downstream: the token comes in on the left, serial data goes out on the left, and upstream token and data use the right. `dir_i`=1 mirrors this. The unused side's outputs stay 0.
- R11: A token received while no event is held produces no output and no upstream token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disc_i | input | 64 | Discriminator bits, one per channel |
| trig_i | input | 1 | Trigger: capture an event |
| cal_strobe_i | input | 1 | Calibration strobe |
| cal_pulse_o | output | 64 | Per-channel calibration pulse enable |
| fast_or_o | output | 1 | OR of trigger-enabled channels |
| cfg_we_i | input | 1 | Mask write enable |
| cfg_sel_i | input | 2 | Mask select: 0 calibration, 1 trigger, 2 data |
| cfg_data_i | input | 64 | Mask write value |
| dir_i | input | 1 | 0: downstream on left, 1: downstream on right |
| chain_end_i | input | 1 | Chip is the upstream end of its chain segment |
| tok_l_i | input | 1 | Token from left neighbour |
| tok_r_i | input | 1 | Token from right neighbour |
| tok_l_o | output | 1 | Token to left neighbour |
| tok_r_o | output | 1 | Token to right neighbour |
| sin_l_v_i | input | 1 | Serial valid from left |
| sin_l_d_i | input | 1 | Serial bit from left |
| sin_l_last_i | input | 1 | Serial last from left |
| sin_r_v_i | input | 1 | Serial valid from right |
| sin_r_d_i | input | 1 | Serial bit from right |
| sin_r_last_i | input | 1 | Serial last from right |
| sout_l_v_o | output | 1 | Serial valid to left |
| sout_l_d_o | output | 1 | Serial bit to left |
| sout_l_last_o | output | 1 | Serial last to left |
| sout_r_v_o | output | 1 | Serial valid to right |
| sout_r_d_o | output | 1 | Serial bit to right |
| sout_r_last_o | output | 1 | Serial last to right |
| ovf_o | output | 1 | Sticky buffer overflow flag |

## Verification
Readout is tried with four kinds of event. An empty event tells the single-bit record apart from a full one. A sparse pattern with channel 0 and channel 63 set catches bit-order and off-by-one errors. A dense alternating pattern catches inverted or shifted bits. An event whose only hits are data-masked shows that masking comes before the header decision. Each kind is read both as chain end and with an upstream stream in both directions, which separates the own-record framing from the pass-through and the side selection. A buffer filled past eight, and a trigger placed in the middle of a readout, show that overflow drops only the ninth event and that capture during readout does not disturb the record being sent.

// File: rtl/shb_pkg.sv
package shb_pkg;
    typedef enum logic [1:0] {
        SR_IDLE = 2'd0,
        SR_SEND = 2'd1,
        SR_REQ  = 2'd2,
        SR_PASS = 2'd3
    } rd_state_e;

    localparam logic [1:0] SEL_CAL  = 2'd0;
    localparam logic [1:0] SEL_TRIG = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
endpackage

// File: rtl/shb_masks.sv
module shb_masks #(
    parameter int NCH = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_i,
    input  logic [1:0]     sel_i,
    input  logic [NCH-1:0] data_i,
    output logic [NCH-1:0] cal_m_o,
    output logic [NCH-1:0] trig_m_o,
    output logic [NCH-1:0] data_m_o
);
    import shb_pkg::*;

    typedef struct packed {
        logic [NCH-1:0] cal;
        logic [NCH-1:0] trig;
        logic [NCH-1:0] data;
    } mask_t;

    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (we_i) begin
            case (sel_i)
                SEL_CAL:  m_d.cal  = data_i;
                SEL_TRIG: m_d.trig = data_i;
                SEL_DATA: m_d.data = data_i;
                default:  m_d = m_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign cal_m_o  = m_q.cal;
    assign trig_m_o = m_q.trig;
    assign data_m_o = m_q.data;

    // R4
    sel_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == 2'd3) |=> ($stable(m_q.cal) && $stable(m_q.trig) && $stable(m_q.data)));
endmodule

// File: rtl/shb_event_fifo.sv
module shb_event_fifo #(
    parameter int NCH   = 64,
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_i,
    input  logic [NCH-1:0] push_data_i,
    input  logic           pop_i,
    output logic [NCH-1:0] head_o,
    output logic           empty_o,
    output logic           ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][NCH-1:0] mem;
        logic [AW-1:0]             wr;
        logic [AW-1:0]             rd;
        logic [CW-1:0]             cnt;
        logic                      ovf;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop, full;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (f_q.cnt == CW'(DEPTH));
    assign empty_o = (f_q.cnt == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty_o;

    always_comb begin
        f_d = f_q;
        if (push_i && full) f_d.ovf = 1'b1;
        if (do_push) begin
            f_d.mem[f_q.wr] = push_data_i;
            f_d.wr          = ptr_inc(f_q.wr);
        end
        if (do_pop) f_d.rd = ptr_inc(f_q.rd);
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_o = f_q.mem[f_q.rd];
    assign ovf_o  = f_q.ovf;

    // R6
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(DEPTH));
    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.ovf |=> f_q.ovf);
    // R6
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> (f_q.cnt == CW'(DEPTH) && f_q.ovf));
    // R5
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full) |=> !empty_o);
endmodule

// File: rtl/shb_serializer.sv
module shb_serializer #(
    parameter int NCH = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tok_i,
    input  logic           chain_end_i,
    input  logic [NCH-1:0] head_i,
    input  logic           empty_i,
    input  logic           up_v_i,
    input  logic           up_d_i,
    input  logic           up_last_i,
    output logic           pop_o,
    output logic           out_v_o,
    output logic           out_d_o,
    output logic           out_last_o,
    output logic           tok_o
);
    import shb_pkg::*;

    localparam int IW = $clog2(NCH);

    typedef struct packed {
        rd_state_e     st;
        logic [IW-1:0] idx;
        logic          v;
        logic          d;
        logic          last;
        logic          tok;
    } ser_t;

    ser_t s_d, s_q;
    logic hdr;

    assign hdr = |head_i;

    always_comb begin
        s_d      = s_q;
        s_d.v    = 1'b0;
        s_d.d    = 1'b0;
        s_d.last = 1'b0;
        s_d.tok  = 1'b0;
        pop_o    = 1'b0;
        case (s_q.st)
            SR_IDLE: begin
                if (tok_i && !empty_i) begin
                    s_d.v   = 1'b1;
                    s_d.d   = hdr;
                    s_d.idx = '0;
                    if (hdr) begin
                        s_d.st = SR_SEND;
                    end else if (chain_end_i) begin
                        s_d.last = 1'b1;
                        pop_o    = 1'b1;
                    end else begin
                        s_d.st = SR_REQ;
                    end
                end
            end
            SR_SEND: begin
                s_d.v = 1'b1;
                s_d.d = head_i[s_q.idx];
                if (s_q.idx == IW'(NCH - 1)) begin
                    if (chain_end_i) begin
                        s_d.last = 1'b1;
                        s_d.st   = SR_IDLE;
                        pop_o    = 1'b1;
                    end else begin
                        s_d.st = SR_REQ;
                    end
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            SR_REQ: begin
                s_d.tok = 1'b1;
                s_d.st  = SR_PASS;
            end
            SR_PASS: begin
                s_d.v    = up_v_i;
                s_d.d    = up_v_i && up_d_i;
                s_d.last = up_v_i && up_last_i;
                if (up_v_i && up_last_i) begin
                    s_d.st = SR_IDLE;
                    pop_o  = 1'b1;
                end
            end
            default: s_d.st = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SR_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign out_v_o    = s_q.v;
    assign out_d_o    = s_q.d;
    assign out_last_o = s_q.last;
    assign tok_o      = s_q.tok;

    // R9
    tok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_o |=> !tok_o);
    // R8
    start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SR_IDLE && tok_i && !empty_i) |=> out_v_o);
    // R11
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SR_IDLE && empty_i) |=> (!out_v_o && !tok_o));
endmodule

// File: rtl/strip_hit_buffer.sv
module strip_hit_buffer #(
    parameter int NCH   = 64,
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] disc_i,
    input  logic           trig_i,
    input  logic           cal_strobe_i,
    output logic [NCH-1:0] cal_pulse_o,
    output logic           fast_or_o,
    input  logic           cfg_we_i,
    input  logic [1:0]     cfg_sel_i,
    input  logic [NCH-1:0] cfg_data_i,
    input  logic           dir_i,
    input  logic           chain_end_i,
    input  logic           tok_l_i,
    input  logic           tok_r_i,
    output logic           tok_l_o,
    output logic           tok_r_o,
    input  logic           sin_l_v_i,
    input  logic           sin_l_d_i,
    input  logic           sin_l_last_i,
    input  logic           sin_r_v_i,
    input  logic           sin_r_d_i,
    input  logic           sin_r_last_i,
    output logic           sout_l_v_o,
    output logic           sout_l_d_o,
    output logic           sout_l_last_o,
    output logic           sout_r_v_o,
    output logic           sout_r_d_o,
    output logic           sout_r_last_o,
    output logic           ovf_o
);
    logic [NCH-1:0] cal_m, trig_m, data_m, head;
    logic           empty, pop;
    logic           tok_dn, up_v, up_d, up_last;
    logic           ser_v, ser_d, ser_last, ser_tok;

    shb_masks #(.NCH(NCH)) u_masks (
        .clk(clk), .rst_n(rst_n),
        .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
        .cal_m_o(cal_m), .trig_m_o(trig_m), .data_m_o(data_m)
    );

    shb_event_fifo #(.NCH(NCH), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(trig_i), .push_data_i(disc_i & ~data_m),
        .pop_i(pop), .head_o(head), .empty_o(empty), .ovf_o(ovf_o)
    );

    // downstream side selects token source and upstream data source
    assign tok_dn  = dir_i ? tok_r_i      : tok_l_i;
    assign up_v    = dir_i ? sin_l_v_i    : sin_r_v_i;
    assign up_d    = dir_i ? sin_l_d_i    : sin_r_d_i;
    assign up_last = dir_i ? sin_l_last_i : sin_r_last_i;

    shb_serializer #(.NCH(NCH)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .tok_i(tok_dn), .chain_end_i(chain_end_i),
        .head_i(head), .empty_i(empty),
        .up_v_i(up_v), .up_d_i(up_d), .up_last_i(up_last),
        .pop_o(pop), .out_v_o(ser_v), .out_d_o(ser_d),
        .out_last_o(ser_last), .tok_o(ser_tok)
    );

    assign sout_l_v_o    = !dir_i && ser_v;
    assign sout_l_d_o    = !dir_i && ser_d;
    assign sout_l_last_o = !dir_i && ser_last;
    assign sout_r_v_o    = dir_i && ser_v;
    assign sout_r_d_o    = dir_i && ser_d;
    assign sout_r_last_o = dir_i && ser_last;
    assign tok_l_o       = dir_i && ser_tok;
    assign tok_r_o       = !dir_i && ser_tok;

    assign fast_or_o   = |(disc_i & ~trig_m);
    assign cal_pulse_o = cal_m & {NCH{cal_strobe_i}};

    // R7
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R10
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sout_l_v_o && sout_r_v_o) && !(tok_l_o && tok_r_o));
endmodule

// File: tb/sim_strip_hit_buffer.sv
module sim_strip_hit_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] disc_i = '0, cfg_data_i = '0, cal_pulse_o;
    logic trig_i = 0, cal_strobe_i = 0, fast_or_o, cfg_we_i = 0;
    logic [1:0] cfg_sel_i = '0;
    logic dir_i = 0, chain_end_i = 1, tok_l_i = 0, tok_r_i = 0, tok_l_o, tok_r_o;
    logic sin_l_v_i = 0, sin_l_d_i = 0, sin_l_last_i = 0;
    logic sin_r_v_i = 0, sin_r_d_i = 0, sin_r_last_i = 0;
    logic sout_l_v_o, sout_l_d_o, sout_l_last_o, sout_r_v_o, sout_r_d_o, sout_r_last_o, ovf_o;

    int total = 0, bad = 0, cycles = 0;
    logic [NCH-1:0] m_cal = '0, m_trig = '0, m_data = '0;
    logic [NCH-1:0] mq[$];
    bit ovf_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strip_hit_buffer #(.NCH(NCH), .DEPTH(8)) u0 (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [NCH-1:0] val);
        @(negedge clk);
        cfg_we_i = 1; cfg_sel_i = sel; cfg_data_i = val;
        @(negedge clk);
        cfg_we_i = 0;
        case (sel)
            2'd0: m_cal = val;
            2'd1: m_trig = val;
            2'd2: m_data = val;
            default: ;
        endcase
    endtask

    function automatic void model_trig(input logic [NCH-1:0] pat);
        if (mq.size() < 8) mq.push_back(pat & ~m_data);
        else ovf_m = 1;
    endfunction

    task automatic trig(input logic [NCH-1:0] pat);
        @(negedge clk);
        disc_i = pat; trig_i = 1;
        @(negedge clk);
        trig_i = 0;
        model_trig(pat);
    endtask

    function automatic void set_up(input bit d, input bit v, input bit b, input bit l);
        if (d) begin sin_l_v_i = v; sin_l_d_i = b; sin_l_last_i = l; end
        else   begin sin_r_v_i = v; sin_r_d_i = b; sin_r_last_i = l; end
    endfunction

    // one readout with reference model compared every clock
    task automatic readout(input bit d, input bit cend, input int up_n,
                           input logic [127:0] up_bits, input bit trig_mid,
                           input logic [NCH-1:0] mid_pat);
        bit exp[$];
        logic [NCH-1:0] ev;
        bit started = 0, done = 0;
        int ptr = 0;
        ev = mq.pop_front();
        if (ev == '0) exp.push_back(1'b0);
        else begin
            exp.push_back(1'b1);
            for (int i = 0; i < NCH; i++) exp.push_back(ev[i]);
        end
        if (!cend) for (int i = 0; i < up_n; i++) exp.push_back(up_bits[i]);
        @(negedge clk);
        dir_i = d; chain_end_i = cend;
        if (d) tok_r_i = 1; else tok_l_i = 1;
        @(negedge clk);
        tok_l_i = 0; tok_r_i = 0;
        for (int cyc = 0; cyc < 400 && !done; cyc++) begin
            logic dv, dd, dl, wv, tup, tdn;
            dv  = d ? sout_r_v_o : sout_l_v_o;
            dd  = d ? sout_r_d_o : sout_l_d_o;
            dl  = d ? sout_r_last_o : sout_l_last_o;
            wv  = d ? sout_l_v_o : sout_r_v_o;
            tup = d ? tok_l_o : tok_r_o;
            tdn = d ? tok_r_o : tok_l_o;
            if (cyc == 0) chk(dv == 1'b1, "R8 header next cycle", NCH'(dv), NCH'(1));
            if (wv || tdn) chk(1'b0, "R10 unused side active", NCH'({wv, tdn}), '0);
            if (dv) begin
                bit e;
                if (exp.size() == 0) begin
                    chk(1'b0, "R9 extra bit", NCH'(dd), '0);
                    done = 1;
                end else begin
                    e = exp.pop_front();
                    chk(dd == e, "R7 record bit", NCH'(dd), NCH'(e));
                    chk(dl == (exp.size() == 0), "R9 last flag", NCH'(dl), NCH'(exp.size() == 0));
                    if (dl) done = 1;
                end
            end
            if (tup) begin
                if (cend) chk(1'b0, "R9 token at chain end", NCH'(1), '0);
                started = 1;
            end
            if (started && ptr < up_n) begin
                set_up(d, 1'b1, up_bits[ptr], ptr == up_n - 1);
                ptr++;
            end else set_up(d, 1'b0, 1'b0, 1'b0);
            if (trig_mid && cyc == 5) begin disc_i = mid_pat; trig_i = 1; end
            if (trig_mid && cyc == 6) begin trig_i = 0; model_trig(mid_pat); end
            @(negedge clk);
        end
        set_up(d, 1'b0, 1'b0, 1'b0);
        trig_i = 0;
        chk(exp.size() == 0 && done, "R9 stream complete", NCH'(exp.size()), '0);
        repeat (2) @(negedge clk);
    endtask

    task automatic empty_tok(input bit d);
        @(negedge clk);
        dir_i = d;
        if (d) tok_r_i = 1; else tok_l_i = 1;
        @(negedge clk);
        tok_l_i = 0; tok_r_i = 0;
        for (int i = 0; i < 6; i++) begin
            chk(!(sout_l_v_o || sout_r_v_o || tok_l_o || tok_r_o), "R11 empty token ignored",
                NCH'({sout_l_v_o, sout_r_v_o, tok_l_o, tok_r_o}), '0);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [127:0] up;
        up = 128'h0;
        for (int i = 0; i < 128; i++) up[i] = ((i * 7) % 5) < 2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!(sout_l_v_o || sout_r_v_o || tok_l_o || tok_r_o || ovf_o), "R1 idle outputs",
            NCH'({sout_l_v_o, sout_r_v_o, tok_l_o, tok_r_o, ovf_o}), '0);
        cal_strobe_i = 1; disc_i = '1;
        #1;
        chk(cal_pulse_o == '0, "R1 cal mask zero", cal_pulse_o, '0);
        chk(fast_or_o == 1'b1, "R1 trig mask zero", NCH'(fast_or_o), NCH'(1));
        cal_strobe_i = 0;
        empty_tok(0);

        // R2 fast OR with trigger mask
        cfg(2'd1, 64'hFFFF_FFFF_FFFF_FFF0);
        disc_i = 64'h8000_0000_0000_0000; #1;
        chk(fast_or_o == 1'b0, "R2 masked hit", NCH'(fast_or_o), '0);
        disc_i = 64'h0000_0000_0000_0004; #1;
        chk(fast_or_o == 1'b1, "R2 enabled hit", NCH'(fast_or_o), NCH'(1));
        disc_i = '0; #1;
        chk(fast_or_o == 1'b0, "R2 no hit", NCH'(fast_or_o), '0);

        // R3 calibration pulse gating
        cfg(2'd0, 64'h0123_4567_89AB_CDEF);
        cal_strobe_i = 0; #1;
        chk(cal_pulse_o == '0, "R3 strobe low", cal_pulse_o, '0);
        cal_strobe_i = 1; #1;
        chk(cal_pulse_o == m_cal, "R3 strobe high", cal_pulse_o, m_cal);

        // R4 select 3 writes nothing
        cfg(2'd3, '1);
        #1;
        chk(cal_pulse_o == m_cal, "R4 sel3 cal kept", cal_pulse_o, m_cal);
        disc_i = 64'h1; #1;
        chk(fast_or_o == 1'b1, "R4 sel3 trig kept", NCH'(fast_or_o), NCH'(1));
        cal_strobe_i = 0;

        // R5 R7 R9 event kinds, chain end, direction 0 and 1
        trig(64'h0);
        trig(64'h8000_0000_0000_0001);
        trig(64'hAAAA_5555_AAAA_5555);
        readout(0, 1, 0, up, 0, '0);
        readout(0, 1, 0, up, 0, '0);
        readout(1, 1, 0, up, 0, '0);

        // R7 data mask hides all hits -> header 0
        cfg(2'd2, 64'h0000_0000_FFFF_0000);
        trig(64'h0000_0000_0F0F_0000);
        trig(64'h0000_0001_00F0_0000);
        // R10 pass-through in both directions
        readout(0, 0, 37, up, 0, '0);
        readout(1, 0, 90, up, 0, '0);

        // R5 trigger during readout
        trig(64'hFFFF_0000_0000_FFFF);
        readout(1, 0, 12, up, 1, 64'h0000_0040_0000_0000);
        readout(0, 1, 0, up, 0, '0);

        // R6 overflow
        chk(ovf_o == 1'b0, "R6 no overflow yet", NCH'(ovf_o), '0);
        for (int i = 0; i < 9; i++) trig(64'h1 << (i * 7));
        @(negedge clk);
        chk(ovf_o == ovf_m, "R6 overflow set", NCH'(ovf_o), NCH'(ovf_m));
        for (int i = 0; i < 8; i++) readout(i % 2, 1, 0, up, 0, '0);
        empty_tok(1);
        chk(ovf_o == 1'b1, "R6 overflow sticky", NCH'(ovf_o), NCH'(1));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule